// File: doc/BRIEF.md
# Timer Output Compare Channel

This block watches one of two free-running 16-bit timers and compares the selected one against a programmed event time. When the timer moves into equality with the event time, the channel performs an action on its output pin: hold, drive low, drive high or invert. In the same clock it can also emit a one-cycle start-conversion pulse for an A/D converter, a one-cycle reload pulse for an external waveform generator, and a one-cycle event interrupt. A simultaneous-capture option copies the timer value at the compare instant into a readable capture register.

Software programs the channel through one write port. A write either loads the event time or loads the control word. A rearm option chooses between two behaviours. In the first, the channel fires on every new match. In the second, it fires once and then waits for the next write to the event time.

Top module: `occ_channel`

## Requirements
- R1: After reset, `pin_out`, `conv_pulse`, `reload_pulse`, `evt_irq` and `cap_time` are all 0. The channel is disarmed until the event time is written, so no action occurs even if a timer equals the reset event time of 0.
- R2: `wr_en` with `wr_sel`=0 loads `wr_data` into the event time. `wr_en` with `wr_sel`=1 loads `wr_data[6:0]` into the control word. The control fields are: bits [1:0] pin action, bit 2 timer select, bit 3 rearm, bit 4 conversion enable, bit 5 simultaneous capture, bit 6 reload enable. A write is used for comparison from the next cycle, and an event-time write arms the channel.
- R3: A match fires when the channel is armed and the selected timer, sampled on a clock edge, equals the event time while it did not equal it on the previous edge. A write of the event time counts as a fresh start for this rule. The outputs of the match appear right after that edge.
- R4: The pin action encoding is 00 hold, 01 drive 0, 10 drive 1, 11 invert. The pin changes only on a match.
- R5: With the rearm bit set, the channel fires again on each later transition into equality, with no further write.
- R6: With the rearm bit clear, the channel disarms after one match. It stays silent on later matches until the event time is written again, even when the value written is unchanged and the timer is still equal.
- R7: A timer that stays at the event-time value for several cycles produces only one match.
- R8: Timer select 0 compares `timer_a` and 1 compares `timer_b`. The unselected timer has no effect.
- R9: On a match with the conversion enable set, `conv_pulse` is high for that cycle.
- R10: On a match with simultaneous capture set, `cap_time` takes the selected timer value. Otherwise `cap_time` keeps its value.
- R11: `reload_pulse` is high on a match only when both simultaneous capture and reload enable are set.
- R12: `evt_irq` is high for one cycle on every match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_a | input | 16 | First free-running timer |
| timer_b | input | 16 | Second free-running timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 event time, 1 control word |
| wr_data | input | 16 | Write data |
| pin_out | output | 1 | Compare output pin |
| conv_pulse | output | 1 | Start-conversion pulse |
| reload_pulse | output | 1 | Waveform reload pulse |
| evt_irq | output | 1 | Event interrupt pulse |
| cap_time | output | 16 | Timer value captured at the last simultaneous-capture match |

## Verification
The timer is walked up to the event time, past it, and back to it. This separates single-shot mode, where there is no second action, from rearm mode, where the action repeats. Holding the timer at the event time for several cycles shows that a stalled timer does not retrigger. Rewriting an unchanged event time while the timer is still equal shows that the write alone rearms the channel. Driving the matching value on the unselected timer, then on the selected one, confirms the select. Switching the capture and reload enables on and off between matches shows that each side output depends on its own bit.

// File: rtl/occ_pkg.sv
package occ_pkg;

    localparam int TIMER_W = 16;
    localparam int CTRL_W  = 7;

    typedef enum logic [1:0] {
        PIN_HOLD   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_HIGH   = 2'b10,
        PIN_INVERT = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic     reload_en;
        logic     simcap;
        logic     conv_en;
        logic     rearm;
        logic     tsel;
        pin_act_e act;
    } occ_ctrl_t;

    function automatic logic next_pin(input pin_act_e act, input logic cur);
        case (act)
            PIN_LOW:    next_pin = 1'b0;
            PIN_HIGH:   next_pin = 1'b1;
            PIN_INVERT: next_pin = ~cur;
            default:    next_pin = cur;
        endcase
    endfunction

endpackage

// File: rtl/occ_regs.sv
module occ_regs
    import occ_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] evt_time,
    output occ_ctrl_t     ctrl,
    output logic          wr_evt
);

    assign wr_evt = wr_en && !wr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_time <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            if (wr_sel) ctrl     <= occ_ctrl_t'(wr_data[CTRL_W-1:0]);
            else        evt_time <= wr_data;
        end
    end

endmodule

// File: rtl/occ_match.sv
module occ_match
    import occ_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic [TW-1:0] evt_time,
    input  occ_ctrl_t     ctrl,
    input  logic          wr_evt,
    output logic [TW-1:0] sel_time,
    output logic          fire
);

    logic armed_q;
    logic eq_prev_q;
    logic raw_eq;

    assign sel_time = ctrl.tsel ? timer_b : timer_a;
    assign raw_eq   = (sel_time == evt_time);
    assign fire     = armed_q && raw_eq && !eq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            eq_prev_q <= 1'b0;
        end else begin
            if (wr_evt)                    armed_q <= 1'b1;
            else if (fire && !ctrl.rearm)  armed_q <= 1'b0;
            eq_prev_q <= wr_evt ? 1'b0 : raw_eq;
        end
    end

endmodule

// File: rtl/occ_action.sv
module occ_action
    import occ_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  occ_ctrl_t     ctrl,
    input  logic [TW-1:0] sel_time,
    output logic          pin_q,
    output logic          conv_q,
    output logic          reload_q,
    output logic          irq_q,
    output logic [TW-1:0] cap_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            conv_q   <= 1'b0;
            reload_q <= 1'b0;
            irq_q    <= 1'b0;
            cap_q    <= '0;
        end else begin
            conv_q   <= fire && ctrl.conv_en;
            reload_q <= fire && ctrl.simcap && ctrl.reload_en;
            irq_q    <= fire;
            if (fire) begin
                pin_q <= next_pin(ctrl.act, pin_q);
                if (ctrl.simcap) cap_q <= sel_time;
            end
        end
    end

endmodule

// File: rtl/occ_channel.sv
module occ_channel
    import occ_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic          pin_out,
    output logic          conv_pulse,
    output logic          reload_pulse,
    output logic          evt_irq,
    output logic [TW-1:0] cap_time
);

    logic [TW-1:0] evt_time;
    logic [TW-1:0] sel_time;
    occ_ctrl_t     ctrl;
    logic          wr_evt;
    logic          fire;

    occ_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .evt_time(evt_time), .ctrl(ctrl), .wr_evt(wr_evt)
    );

    occ_match #(.TW(TW)) u_match (
        .clk(clk), .rst(rst), .timer_a(timer_a), .timer_b(timer_b),
        .evt_time(evt_time), .ctrl(ctrl), .wr_evt(wr_evt),
        .sel_time(sel_time), .fire(fire)
    );

    occ_action #(.TW(TW)) u_action (
        .clk(clk), .rst(rst), .fire(fire), .ctrl(ctrl), .sel_time(sel_time),
        .pin_q(pin_out), .conv_q(conv_pulse), .reload_q(reload_pulse),
        .irq_q(evt_irq), .cap_q(cap_time)
    );

endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk
    import occ_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] timer_a,
    input logic [TW-1:0] timer_b,
    input logic [TW-1:0] evt_time,
    input occ_ctrl_t     ctrl,
    input logic          pin_out,
    input logic          conv_pulse,
    input logic          reload_pulse,
    input logic          evt_irq,
    input logic [TW-1:0] cap_time
);

    logic [TW-1:0] chk_sel;
    assign chk_sel = ctrl.tsel ? timer_b : timer_a;

    assert_match_equal_R3: assert property (@(posedge clk) disable iff (rst)
        evt_irq |-> ($past(chk_sel) == $past(evt_time)));

    assert_pin_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !evt_irq |-> $stable(pin_out));

    assert_conv_with_irq_R9: assert property (@(posedge clk) disable iff (rst)
        conv_pulse |-> evt_irq);

    assert_cap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !evt_irq |-> $stable(cap_time));

    assert_cap_value_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_irq && $past(ctrl.simcap)) |-> (cap_time == $past(chk_sel)));

    assert_reload_gated_R11: assert property (@(posedge clk) disable iff (rst)
        reload_pulse |-> (evt_irq && $past(ctrl.simcap) && $past(ctrl.reload_en)));

endmodule

bind occ_channel occ_channel_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .timer_a(timer_a), .timer_b(timer_b),
    .evt_time(evt_time), .ctrl(ctrl), .pin_out(pin_out),
    .conv_pulse(conv_pulse), .reload_pulse(reload_pulse),
    .evt_irq(evt_irq), .cap_time(cap_time)
);

// File: tb/occ_channel_tb_top.sv
module occ_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] timer_a = '0;
    logic [15:0] timer_b = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pin_out, conv_pulse, reload_pulse, evt_irq;
    logic [15:0] cap_time;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        pin;
        logic        conv;
        logic        rel;
        logic        irq;
        bit          capchk;
        logic [15:0] cap;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    occ_channel dut_i (
        .clk(clk), .rst(rst), .timer_a(timer_a), .timer_b(timer_b),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pin_out(pin_out), .conv_pulse(conv_pulse), .reload_pulse(reload_pulse),
        .evt_irq(evt_irq), .cap_time(cap_time)
    );

    task automatic cyc(input logic [15:0] ta, input logic [15:0] tb,
                       input bit we, input bit sel, input logic [15:0] d,
                       input logic p, input logic cv, input logic rl, input logic ir,
                       input bit cc, input logic [15:0] cp, input string tag);
        exp_t e;
        @(negedge clk);
        timer_a = ta; timer_b = tb; wr_en = we; wr_sel = sel; wr_data = d;
        e.pin = p; e.conv = cv; e.rel = rl; e.irq = ir;
        e.capchk = cc; e.cap = cp; e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pin_out !== e.pin || conv_pulse !== e.conv || reload_pulse !== e.rel ||
                evt_irq !== e.irq || (e.capchk && cap_time !== e.cap)) begin
                errors++;
                $display("FAIL %s: got pin=%b conv=%b rel=%b irq=%b cap=%0d exp pin=%b conv=%b rel=%b irq=%b cap=%0d",
                         e.tag, pin_out, conv_pulse, reload_pulse, evt_irq, cap_time,
                         e.pin, e.conv, e.rel, e.irq, e.cap);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (pin_out !== 0 || conv_pulse !== 0 || reload_pulse !== 0 || evt_irq !== 0 || cap_time !== 0) begin
            errors++;
            $display("FAIL R1: got pin=%b conv=%b rel=%b irq=%b cap=%0d exp all 0",
                     pin_out, conv_pulse, reload_pulse, evt_irq, cap_time);
        end
        // R1 timer 0 equals reset event time, channel not armed; R2 control = set, timer A, single shot
        cyc(0, 0, 1, 1, 16'h0002,  0,0,0,0, 1, 0, "R1");
        cyc(6, 0, 1, 0, 16'd10,    0,0,0,0, 0, 0, "R2");
        cyc(9, 0, 0, 0, 0,         0,0,0,0, 0, 0, "R3");
        cyc(10,0, 0, 0, 0,         1,0,0,1, 0, 0, "R4");   // set pin, R12 irq
        cyc(11,0, 0, 0, 0,         1,0,0,0, 0, 0, "R12");
        cyc(10,0, 0, 0, 0,         1,0,0,0, 0, 0, "R6");   // disarmed
        // drive 0, rearm
        cyc(3, 0, 1, 1, 16'h0009,  1,0,0,0, 0, 0, "R2");
        cyc(4, 0, 1, 0, 16'd20,    1,0,0,0, 0, 0, "R2");
        cyc(20,0, 0, 0, 0,         0,0,0,1, 0, 0, "R4");
        cyc(20,0, 0, 0, 0,         0,0,0,0, 0, 0, "R7");
        cyc(20,0, 0, 0, 0,         0,0,0,0, 0, 0, "R7");
        cyc(21,0, 0, 0, 0,         0,0,0,0, 0, 0, "R5");
        cyc(20,0, 0, 0, 0,         0,0,0,1, 0, 0, "R5");
        // invert, rearm, conversion
        cyc(0, 0, 1, 1, 16'h001B,  0,0,0,0, 0, 0, "R2");
        cyc(20,0, 0, 0, 0,         1,1,0,1, 0, 0, "R9");
        cyc(5, 0, 0, 0, 0,         1,0,0,0, 0, 0, "R9");
        cyc(20,0, 0, 0, 0,         0,1,0,1, 0, 0, "R4");
        // timer B, set, rearm, simcap, reload
        cyc(0, 0, 1, 1, 16'h006E,  0,0,0,0, 0, 0, "R2");
        cyc(20,19,0, 0, 0,         0,0,0,0, 1, 0, "R8");   // timer A ignored
        cyc(0, 20,0, 0, 0,         1,0,1,1, 1, 20, "R10");
        cyc(0, 21,0, 0, 0,         1,0,0,0, 1, 20, "R11");
        // hold action, reload enable without simcap
        cyc(0, 0, 1, 1, 16'h004C,  1,0,0,0, 1, 20, "R11");
        cyc(0, 1, 1, 0, 16'd300,   1,0,0,0, 1, 20, "R2");
        cyc(0, 300,0,0, 0,         1,0,0,1, 1, 20, "R11");  // no reload, cap kept (R10)
        // invert, timer A, single shot, simcap
        cyc(50,0, 1, 1, 16'h0023,  1,0,0,0, 1, 20, "R2");
        cyc(50,0, 1, 0, 16'd50,    1,0,0,0, 1, 20, "R3");
        cyc(50,0, 0, 0, 0,         0,0,0,1, 1, 50, "R3");
        cyc(50,0, 0, 0, 0,         0,0,0,0, 1, 50, "R6");
        cyc(50,0, 1, 0, 16'd50,    0,0,0,0, 1, 50, "R6");
        cyc(50,0, 0, 0, 0,         1,0,0,1, 1, 50, "R6");  // rearmed by same-value write
        cyc(51,0, 0, 0, 0,         1,0,0,0, 1, 50, "R6");
        @(negedge clk);
        wr_en = 0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule